// File: doc/BRIEF.md
# CAN Card Host Interrupt and Register Bridge

This block sits between a host register bus and a card that carries a single CAN controller. The host selects one of three regions with a region code on every access. Region 0 is a 128-byte bridge area that holds one 32-bit interrupt control and status word. Region 1 is a 128-byte window whose lowest 32 bytes are forwarded as single-byte accesses to the controller's 8-bit port. Region 2 is an 8-byte window that holds a read-only version byte.

The controller's interrupt line reaches the host interrupt output only while the enable bit of the control word is set. A read of the control word always shows the live controller interrupt level in a dedicated status bit, whatever was last written there. A small reset sequencer keeps the controller in reset while the block is in reset and for a short settle time after release. Read data is registered and comes back one cycle after the read strobe, flagged by a valid pulse.

The reset sequencer has two states. HOLD is entered on reset and drives the controller reset. The transition HOLD_DONE moves it to RUN after HOLD_CYC rising edges following release. RUN keeps the controller reset low, and only a new reset leaves it.

Top module: `cancard_bridge`

## Requirements
- R1: A region 0 write at byte offset 0x38 stores all 32 bits of `wdata`. A read of that offset returns the stored bits for every bit position other than 23.
- R2: Bit 23 of a region 0 read at offset 0x38 returns the level of `ctl_irq` sampled at the read strobe, whatever value was written to bit 23.
- R3: `host_irq` is high only when `ctl_irq` is high and bit 13 (enable) of the control word is set. While bit 13 is clear, `host_irq` stays low.
- R4: While `ctl_irq` is high, a write that changes bit 13 makes `host_irq` take the new bit 13 value at the same clock edge that stores the write.
- R5: While the enable bit is set, a change of `ctl_irq` appears on `host_irq` after one rising clock edge.
- R6: Region 0 reads at any offset other than 0x38 return zero. Region 0 writes at other offsets leave the control word and `host_irq` unchanged.
- R7: A region 1 write at offset 0x00 to 0x1F produces a single-cycle `ctl_wr` pulse one edge later, with `ctl_waddr` = offset[4:0] and `ctl_wdata` = `wdata[7:0]`.
- R8: Region 1 accesses at offsets 0x20 to 0x7F never assert `ctl_wr` or `ctl_rd`, and their reads return zero.
- R9: A region 1 read at offset 0x00 to 0x1F asserts `ctl_rd` with `ctl_raddr` = offset[4:0] in the strobe cycle and returns `ctl_rdata` zero-extended in `rdata`.
- R10: A region 2 read at offset 7 returns 0xD0 (version 13 in bits 7:4, zero in bits 3:0). Every other region 2 offset reads zero, and region 2 writes have no effect.
- R11: Reset clears the control word, so `host_irq` is low and a read of offset 0x38 gives zero with `ctl_irq` low. `ctl_rst` is high during reset and falls at the HOLD_CYC-th rising edge after release (HOLD_CYC = 4).
- R12: `rd_valid` is high for exactly the cycle after each cycle in which `rd_en` is high, and `rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rgn_sel | input | 2 | Region code: 0 bridge, 1 controller, 2 version, 3 unused |
| addr | input | 7 | Byte offset within the region |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| ctl_wr | output | 1 | Controller write pulse |
| ctl_waddr | output | 5 | Controller write address |
| ctl_wdata | output | 8 | Controller write data |
| ctl_rd | output | 1 | Controller read strobe |
| ctl_raddr | output | 5 | Controller read address |
| ctl_rdata | input | 8 | Controller read data |
| ctl_irq | input | 1 | Controller interrupt level |
| ctl_rst | output | 1 | Controller reset |
| host_irq | output | 1 | Gated host interrupt |

## Verification
The bench sets status bit 23 in a written word while the controller interrupt is low and again while it is high. A design that stored bit 23 instead of showing the live level would read back the wrong value in one of the two cases. It flips the enable bit while an interrupt is pending and checks the host line right after the write. A design that only re-evaluated the gate on interrupt edges would leave the line stale. It also accesses the controller window just above 0x1F, writes to the neighbour offset 0x3C of the control word, and writes to the version byte. A design with a wrong range decode would leak a controller strobe, corrupt the control word or change the version value.

// File: rtl/cb_pkg.sv
package cb_pkg;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 32;
    localparam int CTL_AW   = 5;
    localparam int CTL_DW   = 8;
    localparam int EN_BIT   = 13;
    localparam int LIVE_BIT = 23;
    localparam logic [ADDR_W-1:0] CSR_OFF = 7'h38;

    typedef enum logic [1:0] {
        RG_BRIDGE = 2'd0,
        RG_CTL    = 2'd1,
        RG_VER    = 2'd2,
        RG_NONE   = 2'd3
    } region_e;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } rst_state_e;
endpackage

// File: rtl/cb_csr.sv
module cb_csr
    import cb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ctl_irq,
    output logic [DATA_W-1:0] rd_word,
    output logic              en_o,
    output logic              host_irq
);
    logic [DATA_W-1:0] csr_q;
    logic [DATA_W-1:0] csr_nxt;
    logic              irq_q;
    logic              at_csr;

    always_comb begin
        at_csr  = (addr == CSR_OFF);
        csr_nxt = (wr_hit && at_csr) ? wdata : csr_q;
    end

    // Gate is recomputed from the next enable, so a write takes effect at its own edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q <= '0;
            irq_q <= 1'b0;
        end else begin
            csr_q <= csr_nxt;
            irq_q <= ctl_irq & csr_nxt[EN_BIT];
        end
    end

    always_comb begin
        rd_word = '0;
        if (at_csr) begin
            rd_word           = csr_q;
            rd_word[LIVE_BIT] = ctl_irq;
        end
    end

    assign en_o     = csr_q[EN_BIT];
    assign host_irq = irq_q;
endmodule

// File: rtl/cb_ctl_port.sv
module cb_ctl_port
    import cb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTL_DW-1:0] wbyte,
    input  logic [CTL_DW-1:0] ctl_rdata,
    output logic              ctl_wr,
    output logic [CTL_AW-1:0] ctl_waddr,
    output logic [CTL_DW-1:0] ctl_wdata,
    output logic              ctl_rd,
    output logic [CTL_AW-1:0] ctl_raddr,
    output logic [CTL_DW-1:0] rd_byte
);
    logic in_win;

    assign in_win = (addr[ADDR_W-1:CTL_AW] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_wr    <= 1'b0;
            ctl_waddr <= '0;
            ctl_wdata <= '0;
        end else begin
            ctl_wr <= wr_sel && in_win;
            if (wr_sel && in_win) begin
                ctl_waddr <= addr[CTL_AW-1:0];
                ctl_wdata <= wbyte;
            end
        end
    end

    assign ctl_rd    = rd_sel && in_win;
    assign ctl_raddr = addr[CTL_AW-1:0];
    assign rd_byte   = in_win ? ctl_rdata : '0;
endmodule

// File: rtl/cb_ver_win.sv
module cb_ver_win
    import cb_pkg::*;
#(
    parameter int VERSION = 13,
    parameter int VER_OFF = 7,
    parameter int WIN_AW  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CTL_DW-1:0] rd_byte
);
    localparam logic [CTL_DW-1:0] VER_BYTE = CTL_DW'(VERSION << 4);

    always_comb begin
        rd_byte = '0;
        if (addr[ADDR_W-1:WIN_AW] == '0 && addr[WIN_AW-1:0] == WIN_AW'(VER_OFF))
            rd_byte = VER_BYTE;
    end
endmodule

// File: rtl/cb_rst_seq.sv
module cb_rst_seq
    import cb_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic ctl_rst
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    rst_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (cnt_q == CW'(HOLD_CYC - 1)) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HOLD) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_HOLD: ctl_rst = 1'b1;
            ST_RUN:  ctl_rst = 1'b0;
        endcase
    end
endmodule

// File: rtl/cancard_bridge.sv
module cancard_bridge
    import cb_pkg::*;
#(
    parameter int HOLD_CYC = 4,
    parameter int VERSION  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        rgn_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic              ctl_wr,
    output logic [CTL_AW-1:0] ctl_waddr,
    output logic [CTL_DW-1:0] ctl_wdata,
    output logic              ctl_rd,
    output logic [CTL_AW-1:0] ctl_raddr,
    input  logic [CTL_DW-1:0] ctl_rdata,
    input  logic              ctl_irq,
    output logic              ctl_rst,
    output logic              host_irq
);
    region_e           rgn;
    logic [DATA_W-1:0] csr_word;
    logic [CTL_DW-1:0] ctl_byte;
    logic [CTL_DW-1:0] ver_byte;
    logic [DATA_W-1:0] rd_mux;
    logic              csr_en_w;

    assign rgn = region_e'(rgn_sel);

    cb_csr u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_en && rgn == RG_BRIDGE),
        .addr     (addr),
        .wdata    (wdata),
        .ctl_irq  (ctl_irq),
        .rd_word  (csr_word),
        .en_o     (csr_en_w),
        .host_irq (host_irq)
    );

    cb_ctl_port u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_sel    (rd_en && rgn == RG_CTL),
        .wr_sel    (wr_en && rgn == RG_CTL),
        .addr      (addr),
        .wbyte     (wdata[CTL_DW-1:0]),
        .ctl_rdata (ctl_rdata),
        .ctl_wr    (ctl_wr),
        .ctl_waddr (ctl_waddr),
        .ctl_wdata (ctl_wdata),
        .ctl_rd    (ctl_rd),
        .ctl_raddr (ctl_raddr),
        .rd_byte   (ctl_byte)
    );

    cb_ver_win #(.VERSION(VERSION)) u_ver (
        .addr    (addr),
        .rd_byte (ver_byte)
    );

    cb_rst_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_rst (ctl_rst)
    );

    always_comb begin
        unique case (rgn)
            RG_BRIDGE: rd_mux = csr_word;
            RG_CTL:    rd_mux = {{(DATA_W-CTL_DW){1'b0}}, ctl_byte};
            RG_VER:    rd_mux = {{(DATA_W-CTL_DW){1'b0}}, ver_byte};
            RG_NONE:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/cancard_bridge_chk.sv
module cancard_bridge_chk
    import cb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [1:0]        rgn_sel,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              rd_valid,
    input logic              ctl_wr,
    input logic              ctl_rd,
    input logic              ctl_irq,
    input logic              ctl_rst,
    input logic              host_irq,
    input logic              csr_en
);
    // R3 R5: host line is last cycle's interrupt gated by the stored enable
    a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (host_irq == ($past(ctl_irq) && csr_en)));

    // R12: valid follows the read strobe by one cycle
    a_r12_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r12_novalid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R8: controller write pulses only for in-window writes
    a_r8_wr_range: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rgn_sel == 2'd1 && addr < 7'h20) |=> !ctl_wr);

    // R8: controller read strobe never without a host read into its window
    a_r8_rd_range: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd |-> (rd_en && rgn_sel == 2'd1 && addr < 7'h20));

    // R10: version window reads zero away from offset 7
    a_r10_ver_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rgn_sel == 2'd2 && addr != 7'd7) |=> (rdata == '0));

    // R11: once released, controller reset stays low
    a_r11_rst_stay: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rst |=> !ctl_rst);
endmodule

bind cancard_bridge cancard_bridge_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .rgn_sel  (rgn_sel),
    .addr     (addr),
    .rdata    (rdata),
    .rd_valid (rd_valid),
    .ctl_wr   (ctl_wr),
    .ctl_rd   (ctl_rd),
    .ctl_irq  (ctl_irq),
    .ctl_rst  (ctl_rst),
    .host_irq (host_irq),
    .csr_en   (csr_en_w)
);

// File: tb/cancard_bridge_tb.sv
module cancard_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  rgn_sel = 2'd0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rd_valid, ctl_wr, ctl_rd, ctl_rst, host_irq;
    logic [4:0]  ctl_waddr, ctl_raddr;
    logic [7:0]  ctl_wdata, ctl_rdata;
    logic        ctl_irq = 1'b0;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    // Controller model: read data encodes the address
    assign ctl_rdata = {3'b101, ctl_raddr};

    cancard_bridge dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] r, input logic [6:0] a, input logic [31:0] d);
        rgn_sel = r; addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] r, input logic [6:0] a, output logic [31:0] d);
        rgn_sel = r; addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
        chk("R12 valid", {31'b0, rd_valid}, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 rst in reset", {31'b0, ctl_rst}, 32'd1);
        chk("R11 host_irq in reset", {31'b0, host_irq}, 32'd0);
        rst_n = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            chk("R11 rst hold", {31'b0, ctl_rst}, 32'd1);
        end
        @(negedge clk);
        chk("R11 rst released", {31'b0, ctl_rst}, 32'd0);
        do_read(2'd0, 7'h38, d);
        chk("R11 csr cleared", d, 32'h0);
        @(negedge clk);
        chk("R12 valid drops", {31'b0, rd_valid}, 32'd0);
    endtask

    task automatic t_csr_live();
        logic [31:0] d;
        ctl_irq = 1'b0;
        do_write(2'd0, 7'h38, 32'h5A80_C3C3);
        do_read(2'd0, 7'h38, d);
        chk("R1 R2 readback irq low", d, 32'h5A00_C3C3);
        ctl_irq = 1'b1;
        @(negedge clk);
        do_read(2'd0, 7'h38, d);
        chk("R2 live bit irq high", d, 32'h5A80_C3C3);
        chk("R3 disabled gate", {31'b0, host_irq}, 32'd0);
    endtask

    task automatic t_enable_toggle();
        do_write(2'd0, 7'h38, 32'h0000_2000);
        chk("R4 enable while pending", {31'b0, host_irq}, 32'd1);
        do_write(2'd0, 7'h38, 32'h0000_0000);
        chk("R4 disable while pending", {31'b0, host_irq}, 32'd0);
    endtask

    task automatic t_follow();
        do_write(2'd0, 7'h38, 32'h0000_2000);
        ctl_irq = 1'b0;
        @(negedge clk);
        chk("R5 follow low", {31'b0, host_irq}, 32'd0);
        ctl_irq = 1'b1;
        @(negedge clk);
        chk("R5 follow high", {31'b0, host_irq}, 32'd1);
    endtask

    task automatic t_other_off();
        logic [31:0] d;
        do_write(2'd0, 7'h3C, 32'hFFFF_FFFF);
        chk("R6 host unchanged", {31'b0, host_irq}, 32'd1);
        do_read(2'd0, 7'h38, d);
        chk("R6 csr untouched", d, 32'h0080_2000);
        do_read(2'd0, 7'h3C, d);
        chk("R6 other reads zero", d, 32'h0);
    endtask

    task automatic t_ctl();
        logic [31:0] d;
        do_write(2'd1, 7'h1F, 32'hFFFF_FF3C);
        chk("R7 wr pulse", {31'b0, ctl_wr}, 32'd1);
        chk("R7 waddr", {27'b0, ctl_waddr}, 32'h1F);
        chk("R7 wdata", {24'b0, ctl_wdata}, 32'h3C);
        @(negedge clk);
        chk("R7 single pulse", {31'b0, ctl_wr}, 32'd0);
        do_write(2'd1, 7'h20, 32'h55);
        chk("R8 no wr above window", {31'b0, ctl_wr}, 32'd0);
        do_read(2'd1, 7'h05, d);
        chk("R9 read in window", d, 32'hA5);
        rgn_sel = 2'd1; addr = 7'h45; rd_en = 1'b1;
        #1;
        chk("R8 no rd strobe", {31'b0, ctl_rd}, 32'd0);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R8 read above window", rdata, 32'h0);
    endtask

    task automatic t_ver();
        logic [31:0] d;
        do_read(2'd2, 7'd7, d);
        chk("R10 version", d, 32'hD0);
        do_read(2'd2, 7'd3, d);
        chk("R10 other zero", d, 32'h0);
        do_write(2'd2, 7'd7, 32'hFF);
        do_read(2'd2, 7'd7, d);
        chk("R10 write ignored", d, 32'hD0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_csr_live();
        t_enable_toggle();
        t_follow();
        t_other_off();
        t_ctl();
        t_ver();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule